// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Pin Interrupts

This block is a general-purpose I/O peripheral for eight pins. It sits on a simple byte-wide register bus: an address, a write strobe with write data, and a read strobe with combinational read data. Each pin can be set as an input or an output. The output value of each pin is held in a data register. Software reaches that register through a 256-word address window, in which the word address bits act as a per-pin mask. A single pin can therefore be set or read without a read-modify-write sequence.

Every pin also has an interrupt detector. Each detector can sense a high level, a low level, a rising edge, a falling edge, or both edges. Pin inputs first pass through a two-flop synchroniser. Edge events are latched until software clears them by writing ones. Level events are not latched and follow the input. The block keeps a raw status register and an enable register. Masked status is the raw status gated by the enables, and the OR of the masked status drives one interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all configuration registers and the output data register are 0. This gives all pins as inputs, edge sensing, falling polarity, no both-edge sensing and interrupts disabled. The latched edge status is also 0, so `pin_oe`, `pin_out` and `irq_out` are all 0.
- R2: A write to byte address 0x400 sets the direction register. Bit n = 1 drives pin n as an output, and `pin_oe` equals this register. A read of 0x400 returns it.
- R3: A write to an address below 0x400 uses address bits [9:2] as a mask. Data bit n changes to write-data bit n only when mask bit n is 1 and pin n is an output. `pin_out` bit n is the data bit when pin n is an output and 0 otherwise. Writes to any other address leave the data register unchanged.
- R4: A data write to a pin configured as an input has no effect. When that pin later becomes an output, it drives the value held before that write.
- R5: A read below 0x400 returns bit n equal to mask bit n AND the pin value. The pin value is the data bit for an output pin and the synchronised input for an input pin. An input change shows on the second rising clock edge after it, and not on the first.
- R6: With sense bit n = 1 (0x404), raw status bit n is 1 while the synchronised input equals event bit n (0x40C; 1 = high, 0 = low). The bit drops when the input leaves that level, with no clear write.
- R7: With sense bit n = 0, an edge of the polarity given by event bit n (1 = rising, 0 = falling) sets raw status bit n. The bit stays set after the input returns.
- R8: With both-edges bit n = 1 (0x408) and sense bit n = 0, either transition sets raw status bit n, whatever the event bit holds.
- R9: Writing 1s to 0x41C clears the matching latched edge bits. Bits written as 0 are kept. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R10: 0x410 is the enable register. A read of 0x418 returns the raw status (0x414) AND the enable register. `irq_out` is 1 exactly when that masked value is nonzero.
- R11: Writes to 0x414 and 0x418 change nothing. A read of 0x41C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bound assertions check these rules on every cycle:
- A direction write appears on `pin_oe` in the next cycle.
- The data register changes only in bits that are both masked in and configured as outputs.
- A clear write empties latched edge bits unless a new edge coincides with it, and a coinciding edge always wins.
- `irq_out` stays low while the enables are zero.

The bench scenarios are needed for the rest:
- the exact masked read values;
- the two-edge synchroniser latency;
- level bits falling on their own;
- each polarity and both-edge combination on each pin;
- the arithmetic relation between the enables and the masked status, swept over all 256 enable patterns.

// File: rtl/gpio_pkg.sv
// Package: register offsets and the address decoder shared by the GPIO controller.
// Assumes a 12-bit byte address; offsets below 0x400 form the masked data window.
package gpio_pkg;

    localparam logic [11:0] OFS_DIR   = 12'h400;
    localparam logic [11:0] OFS_SENSE = 12'h404;
    localparam logic [11:0] OFS_BOTH  = 12'h408;
    localparam logic [11:0] OFS_EVENT = 12'h40C;
    localparam logic [11:0] OFS_IEN   = 12'h410;
    localparam logic [11:0] OFS_RAW   = 12'h414;
    localparam logic [11:0] OFS_MSK   = 12'h418;
    localparam logic [11:0] OFS_CLR   = 12'h41C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVENT,
        SEL_IEN,
        SEL_RAW,
        SEL_MSK,
        SEL_CLR
    } reg_sel_t;

    // Map a byte address to the register it selects.
    function automatic reg_sel_t decode_addr(input logic [11:0] a);
        reg_sel_t s;
        if (a[11:10] == 2'b00) begin
            s = SEL_DATA;
        end else begin
            unique case (a)
                OFS_DIR:   s = SEL_DIR;
                OFS_SENSE: s = SEL_SENSE;
                OFS_BOTH:  s = SEL_BOTH;
                OFS_EVENT: s = SEL_EVENT;
                OFS_IEN:   s = SEL_IEN;
                OFS_RAW:   s = SEL_RAW;
                OFS_MSK:   s = SEL_MSK;
                OFS_CLR:   s = SEL_CLR;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Synchronises the asynchronous pin inputs through a chain of STAGES flops and
// keeps a copy of the synchronised value delayed by one clock for edge detection.
// Assumes STAGES >= 2 and a synchronous active-low reset that clears every stage.
module gpio_sync #(
    parameter int NPIN   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] sync_q,
    output logic [NPIN-1:0] prev_q
);

    logic [NPIN-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_chain
        // Each further stage re-times the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
        end
    end

    // Delayed copy of the synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Per-pin interrupt detection. Level sensing is combinational on the synchronised
// input. Edge sensing is latched until a clear bit arrives; a new edge in the
// clear cycle wins. Assumes sync_q/prev_q come from gpio_sync.
module gpio_irq_detect #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] sync_q,
    input  logic [NPIN-1:0] prev_q,
    input  logic [NPIN-1:0] sense_q,
    input  logic [NPIN-1:0] both_q,
    input  logic [NPIN-1:0] event_q,
    input  logic [NPIN-1:0] clr_bits,
    output logic [NPIN-1:0] edge_hit,
    output logic [NPIN-1:0] edge_lat,
    output logic [NPIN-1:0] raw_stat
);

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        logic rise, fall, hit;

        // Classify this pin's transition and qualify it by the configuration.
        always_comb begin
            rise = sync_q[n] & ~prev_q[n];
            fall = ~sync_q[n] & prev_q[n];
            if (sense_q[n])     hit = 1'b0;
            else if (both_q[n]) hit = rise | fall;
            else if (event_q[n]) hit = rise;
            else                hit = fall;
        end

        // Latch edge events; clear on request unless a new edge coincides.
        always_ff @(posedge clk) begin
            if (!rst_n) edge_lat[n] <= 1'b0;
            else        edge_lat[n] <= (edge_lat[n] & ~clr_bits[n]) | hit;
        end

        // Raw status selects live level match or the latched edge.
        always_comb begin
            if (sense_q[n]) raw_stat[n] = ~(sync_q[n] ^ event_q[n]);
            else            raw_stat[n] = edge_lat[n];
        end

        assign edge_hit[n] = hit;
    end

endmodule

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Byte-wide register file: configuration registers, the masked output data
// register, the clear pulse and the read multiplexer. Assumes one-cycle write
// strobes and that address bits [NPIN+1:2] form the data mask.
module gpio_regfile #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_rd,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_view,
    input  logic [NPIN-1:0] raw_stat,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] sense_q,
    output logic [NPIN-1:0] both_q,
    output logic [NPIN-1:0] event_q,
    output logic [NPIN-1:0] ien_q,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] clr_bits
);
    import gpio_pkg::*;

    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + NPIN - 1;

    reg_sel_t        sel;
    logic [NPIN-1:0] win_mask;
    logic [NPIN-1:0] data_we;

    // Decode the address and derive the data-window mask and writable bits.
    always_comb begin
        sel      = decode_addr(bus_addr);
        win_mask = bus_addr[MASK_HI:MASK_LO];
        data_we  = (bus_wr && sel == SEL_DATA) ? (win_mask & dir_q) : '0;
        clr_bits = (bus_wr && sel == SEL_CLR) ? bus_wdata : '0;
    end

    // Configuration registers, written whole on an exact address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            ien_q   <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_DIR:   dir_q   <= bus_wdata;
                SEL_SENSE: sense_q <= bus_wdata;
                SEL_BOTH:  both_q  <= bus_wdata;
                SEL_EVENT: event_q <= bus_wdata;
                SEL_IEN:   ien_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Output data register: only masked-in output pins accept new data.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= (out_q & ~data_we) | (bus_wdata & data_we);
    end

    // Read multiplexer, zero when no read is requested.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_DATA:  bus_rdata = pin_view & win_mask;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_SENSE: bus_rdata = sense_q;
                SEL_BOTH:  bus_rdata = both_q;
                SEL_EVENT: bus_rdata = event_q;
                SEL_IEN:   bus_rdata = ien_q;
                SEL_RAW:   bus_rdata = raw_stat;
                SEL_MSK:   bus_rdata = raw_stat & ien_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_ctrl.sv
// Module: gpio_ctrl (top)
// Eight-line GPIO controller with per-pin interrupts and one combined interrupt.
// Assumes NPIN fits the data-window mask (NPIN <= 8) and a synchronous
// active-low reset.
module gpio_ctrl #(
    parameter int NPIN      = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_rd,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq_out
);

    logic [NPIN-1:0] sync_q, prev_q;
    logic [NPIN-1:0] dir_q, sense_q, both_q, event_q, ien_q, out_q;
    logic [NPIN-1:0] clr_bits, edge_hit, edge_lat, raw_stat, pin_view;

    gpio_sync #(.NPIN(NPIN), .STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (sync_q),
        .prev_q   (prev_q),
        .sense_q  (sense_q),
        .both_q   (both_q),
        .event_q  (event_q),
        .clr_bits (clr_bits),
        .edge_hit (edge_hit),
        .edge_lat (edge_lat),
        .raw_stat (raw_stat)
    );

    gpio_regfile #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_view  (pin_view),
        .raw_stat  (raw_stat),
        .dir_q     (dir_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .event_q   (event_q),
        .ien_q     (ien_q),
        .out_q     (out_q),
        .clr_bits  (clr_bits)
    );

    // Pin value seen by data reads, and the outputs toward the pads.
    always_comb begin
        pin_view = (out_q & dir_q) | (sync_q & ~dir_q);
        pin_out  = out_q & dir_q;
        pin_oe   = dir_q;
        irq_out  = |(raw_stat & ien_q);
    end

endmodule

// File: rtl/gpio_ctrl_chk.sv
// Module: gpio_ctrl_chk
// Cycle-by-cycle properties of gpio_ctrl, attached with bind below.
module gpio_ctrl_chk #(
    parameter int NPIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [11:0]     bus_addr,
    input logic            bus_wr,
    input logic [NPIN-1:0] bus_wdata,
    input logic [NPIN-1:0] pin_oe,
    input logic            irq_out,
    input logic [NPIN-1:0] dir_q,
    input logic [NPIN-1:0] ien_q,
    input logic [NPIN-1:0] out_q,
    input logic [NPIN-1:0] edge_hit,
    input logic [NPIN-1:0] edge_lat
);
    import gpio_pkg::*;

    // R1: registers leave reset cleared.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && ien_q == '0 && out_q == '0 && edge_lat == '0));

    // R2: a direction write appears on the output enables next cycle.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R3: only data-window writes may alter the data register.
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[11:10] == 2'b00) |=> (out_q == $past(out_q)));

    // R4: a data write touches only bits masked in and set as outputs.
    p_data_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:10] == 2'b00) |=>
        (((out_q ^ $past(out_q)) & ~($past(dir_q) & $past(bus_addr[NPIN+1:2]))) == '0));

    // R9: cleared bits without a coinciding edge are empty afterwards.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLR) |=>
        ((edge_lat & $past(bus_wdata) & ~$past(edge_hit)) == '0));

    // R9: a detected edge is always latched, even against a clear.
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((edge_lat & $past(edge_hit)) == $past(edge_hit)));

    // R10: no enables means no combined interrupt.
    p_no_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_out);

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .out_q     (out_q),
    .edge_hit  (edge_hit),
    .edge_lat  (edge_lat)
);

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_out = '0;
    logic [7:0] m_dir = '0;

    always #2.5 clk = ~clk;

    gpio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    // Model of a masked data write per R3/R4.
    task automatic data_wr(input logic [7:0] m, input logic [7:0] d);
        wr({2'b00, m, 2'b00}, d);
        m_out = (m_out & ~(m & m_dir)) | (d & m & m_dir);
    endtask

    task automatic dir_wr(input logic [7:0] d);
        wr(12'h400, d);
        m_dir = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] view;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);
        for (int a = 12'h400; a <= 12'h418; a += 4) begin
            rd(12'(a), r);
            chk("R1 register", r, 8'h00);
        end

        // R2: every direction pattern
        for (int v = 0; v < 256; v++) begin
            dir_wr(8'(v));
            chk("R2 pin_oe", pin_oe, 8'(v));
            rd(12'h400, r);
            chk("R2 readback", r, 8'(v));
        end

        // R3: every mask with all pins as outputs
        dir_wr(8'hFF);
        for (int m = 0; m < 256; m++) begin
            data_wr(8'(m), 8'(m * 37) ^ 8'h5A);
            chk("R3 masked write", pin_out, m_out);
        end
        wr(12'h408, 8'hC3);
        chk("R3 non-data write", pin_out, m_out);
        wr(12'h408, 8'h00);

        // R4: writes to inputs are dropped
        data_wr(8'hFF, 8'h00);
        dir_wr(8'h0F);
        data_wr(8'hFF, 8'hFF);
        chk("R4 partial outputs", pin_out, 8'h0F);
        dir_wr(8'hFF);
        chk("R4 later output", pin_out, 8'h0F);

        // R5: masked reads over mixed directions
        data_wr(8'hFF, 8'h3C);
        dir_wr(8'hF0);
        set_pins(8'hA5);
        for (int m = 0; m < 256; m++) begin
            rd({2'b00, 8'(m), 2'b00}, r);
            view = ((m_out & m_dir) | (8'hA5 & ~m_dir)) & 8'(m);
            chk("R5 masked read", r, view);
        end
        // R5: two-edge synchroniser latency
        dir_wr(8'h00);
        @(negedge clk);
        pin_in = 8'h5A;
        rd(12'h3FC, r);
        chk("R5 after one edge", r, 8'hA5);
        rd(12'h3FC, r);
        chk("R5 after two edges", r, 8'h5A);

        // R6: level sensing on each pin, both polarities
        wr(12'h410, 8'hFF);
        wr(12'h404, 8'hFF);
        for (int e = 0; e < 2; e++) begin
            logic [7:0] idle;
            idle = (e != 0) ? 8'h00 : 8'hFF;
            wr(12'h40C, (e != 0) ? 8'hFF : 8'h00);
            set_pins(idle);
            for (int i = 0; i < 8; i++) begin
                set_pins(idle ^ (8'h01 << i));
                rd(12'h414, r);
                chk("R6 level active", r, 8'h01 << i);
                chk("R6 level irq", {7'b0, irq_out}, 8'h01);
                set_pins(idle);
                rd(12'h414, r);
                chk("R6 level drops", r, 8'h00);
                chk("R6 level irq drops", {7'b0, irq_out}, 8'h00);
            end
        end

        // R7: single-edge sensing per pin and polarity; R9 clear
        set_pins(8'h00);
        wr(12'h404, 8'h00);
        wr(12'h41C, 8'hFF);
        for (int e = 0; e < 2; e++) begin
            wr(12'h40C, (e != 0) ? 8'hFF : 8'h00);
            for (int i = 0; i < 8; i++) begin
                set_pins(8'h01 << i);
                rd(12'h414, r);
                chk("R7 after rise", r, (e != 0) ? (8'h01 << i) : 8'h00);
                set_pins(8'h00);
                rd(12'h414, r);
                chk("R7 latched", r, 8'h01 << i);
                wr(12'h41C, ~(8'h01 << i));
                rd(12'h414, r);
                chk("R9 zero bits kept", r, 8'h01 << i);
                wr(12'h41C, 8'h01 << i);
                rd(12'h414, r);
                chk("R9 cleared", r, 8'h00);
            end
        end

        // R8: both-edge sensing ignores the event bit
        wr(12'h40C, 8'h00);
        wr(12'h408, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            set_pins(8'h01 << i);
            rd(12'h414, r);
            chk("R8 rise", r, 8'h01 << i);
            wr(12'h41C, 8'hFF);
            set_pins(8'h00);
            rd(12'h414, r);
            chk("R8 fall", r, 8'h01 << i);
            wr(12'h41C, 8'hFF);
        end

        // R9: edge coinciding with clear wins
        set_pins(8'h01);
        @(negedge clk);
        pin_in = 8'h00;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 12'h41C; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(12'h414, r);
        chk("R9 edge wins", r, 8'h01);
        wr(12'h41C, 8'h01);
        rd(12'h414, r);
        chk("R9 plain clear", r, 8'h00);

        // R10: masked status and irq over every enable pattern
        wr(12'h408, 8'h00);
        wr(12'h40C, 8'hFF);
        wr(12'h404, 8'hFF);
        set_pins(8'h96);
        for (int v = 0; v < 256; v++) begin
            wr(12'h410, 8'(v));
            rd(12'h418, r);
            chk("R10 masked", r, 8'h96 & 8'(v));
            chk("R10 irq", {7'b0, irq_out}, {7'b0, |(8'h96 & 8'(v))});
        end

        // R11: status writes ignored, clear reads zero
        wr(12'h410, 8'h0F);
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'h00);
        rd(12'h414, r);
        chk("R11 raw unchanged", r, 8'h96);
        rd(12'h418, r);
        chk("R11 masked unchanged", r, 8'h06);
        rd(12'h41C, r);
        chk("R11 clear reads zero", r, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule